// File: doc/BRIEF.md
# Auto-Increment Pointer Data Port

This block gives a host a narrow programmed-I/O window onto a byte-addressed buffer RAM held inside the block. The host never addresses the RAM directly. It first loads a read pointer or a write pointer through two pointer registers. It then moves data through one data-port register. Each data-port write stores at the write pointer, and each data-port read returns the contents at the read pointer. After every access the pointer that was used advances by the access size.

Word accesses and single-byte accesses are both accepted, and they may be mixed freely. This lets a transfer that starts at an odd offset use one byte, then a run of words, then an optional trailing byte. Words are stored little-endian at any byte alignment. The two pointers are independent, so a buffer can be filled and read back without reloading either pointer in between.

The buffer size is built from a number of equal banks, with 64 KB as the largest useful configuration. Pointers wrap modulo the buffer size.

Top module: `pio_window`

## Requirements
- R1: After a synchronous active-low reset, both pointers read back as zero and `rdata` is zero.
- R2: A write with `byte_en`=2'b11 to select 1 loads the read pointer, and one to select 2 loads the write pointer. Only the low log2(buffer size) bits are kept. Reading select 1 or 2 returns that pointer zero-extended to 16 bits. Loading one pointer leaves the other unchanged.
- R3: A data-port write (select 0) with `byte_en`=2'b11 stores `wdata[7:0]` at the write pointer and `wdata[15:8]` at the write pointer plus 1, then advances the write pointer by 2.
- R4: A data-port write with `byte_en`=2'b01 stores `wdata[7:0]` at the write pointer, leaves every other byte unchanged, and advances the write pointer by 1.
- R5: A data-port read presents its data on `rdata` in the cycle after the read strobe. With `byte_en`=2'b11 it returns {byte at pointer+1, byte at pointer} and advances the read pointer by 2. With `byte_en`=2'b01 it returns {8'h00, byte at pointer} and advances the read pointer by 1.
- R6: Word accesses at odd pointer values store and return the same bytes as at even values, so byte and word accesses can be mixed at any offset.
- R7: Pointer advance wraps modulo the buffer size, and a word that starts on the last byte places its high byte at offset 0.
- R8: A data-port access with `byte_en` other than 2'b01 or 2'b11 stores nothing and moves no pointer. A pointer load with `byte_en` other than 2'b11 is ignored.
- R9: Data-port reads never move the write pointer, and data-port writes never move the read pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data port, 1 read pointer, 2 write pointer, 3 unused (reads zero) |
| byte_en | input | 2 | 2'b11 word access, 2'b01 byte access on the low lane |
| wr_stb | input | 1 | Host write strobe, one cycle per access |
| rd_stb | input | 1 | Host read strobe, one cycle per access |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid the cycle after `rd_stb`, held until the next read |

## Verification
The bench builds the block with 64-byte banks and four banks, so the buffer is 256 bytes. With that size, a full fill with the stepping pattern and the pointer wrap from the last byte to offset 0 are reached within a few hundred accesses. The bench fills the whole buffer first with words and then with bytes, and reads each fill back. It then mixes odd-offset runs, ignored enable codes and random accesses of both widths against its own byte-array model.

// File: rtl/pio_window_pkg.sv
// Package: pio_window_pkg
// Shared register-select encoding and access-width codes for the
// pointer data-port window. Assumes a two-bit select and two byte enables.
package pio_window_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_RPTR = 2'd1,
        SEL_WPTR = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    localparam logic [1:0] BE_BYTE = 2'b01;
    localparam logic [1:0] BE_WORD = 2'b11;

endpackage

// File: rtl/pio_ptr.sv
// Module: pio_ptr
// One auto-incrementing byte pointer. A load takes priority over an
// advance; the advance step is 2 for a word and 1 for a byte. Assumes the
// buffer size is a power of two, so width truncation gives the wrap.
module pio_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    input  logic          step_word,
    output logic [AW-1:0] ptr
);

    // Pointer register: load, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ld)
            ptr <= ld_val;
        else if (adv)
            ptr <= ptr + (step_word ? AW'(2) : AW'(1));
    end

    // R2
    load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr == $past(ld_val));

endmodule

// File: rtl/pio_lane_map.sv
// Module: pio_lane_map
// Splits a byte pointer onto two byte-wide lanes (even and odd bytes).
// The low byte of an access sits in the lane named by pointer bit 0. When
// that is the odd lane, the high byte comes from the next even entry. The
// next entry wraps within the lane.
module pio_lane_map #(
    parameter int AW = 11,
    localparam int LW = AW - 1
) (
    input  logic [AW-1:0] ptr,
    output logic [LW-1:0] even_addr,
    output logic [LW-1:0] odd_addr,
    output logic          low_odd
);

    logic [LW-1:0] base;

    // Lane entry addresses for the byte at ptr and the byte after it.
    always_comb begin
        base      = ptr[AW-1:1];
        low_odd   = ptr[0];
        odd_addr  = base;
        even_addr = ptr[0] ? base + LW'(1) : base;
    end

endmodule

// File: rtl/pio_lane_ram.sv
// Module: pio_lane_ram
// Byte-wide RAM for one lane with one write port and one registered read
// port. The read register holds its value until the next read enable.
// The contents have no reset.
module pio_lane_ram #(
    parameter int ENTRIES = 1024,
    localparam int LW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [LW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [LW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [ENTRIES];

    // Storage write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered read, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/pio_window.sv
// Module: pio_window
// Programmed-I/O window onto an internal byte buffer. It has independent
// read and write pointers, one data port, and word or byte access with
// little-endian order at any alignment. Assumes BANK_BYTES * NUM_BANKS is
// a power of two no larger than 64 KB, and one strobe per access.
module pio_window
    import pio_window_pkg::*;
#(
    parameter int BANK_BYTES = 512,
    parameter int NUM_BANKS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic [1:0]  byte_en,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [15:0] wdata,
    output logic [15:0] rdata
);

    localparam int BUF_BYTES    = BANK_BYTES * NUM_BANKS;
    localparam int AW           = $clog2(BUF_BYTES);
    localparam int LANE_ENTRIES = BUF_BYTES / 2;
    localparam int LW           = AW - 1;

    port_sel_e     sel;
    logic          be_word, be_byte;
    logic          dp_wr_word, dp_wr_byte, dp_rd_word, dp_rd_byte;
    logic          ld_rptr, ld_wptr;
    logic [AW-1:0] rptr, wptr;

    logic [LW-1:0] w_even, w_odd, r_even, r_odd;
    logic          w_low_odd, r_low_odd;

    logic [1:0]    lane_we;
    logic [LW-1:0] lane_wa [2];
    logic [7:0]    lane_wd [2];
    logic [LW-1:0] lane_ra [2];
    logic [7:0]    lane_q  [2];
    logic          lane_re;

    logic          rd_is_data_q, rd_byte_q, rd_low_odd_q;
    logic [15:0]   hold_q;
    logic [7:0]    out_lo, out_hi;

    // Access decode from select, enables and strobes.
    always_comb begin
        sel        = port_sel_e'(reg_sel);
        be_word    = (byte_en == BE_WORD);
        be_byte    = (byte_en == BE_BYTE);
        dp_wr_word = wr_stb && sel == SEL_DATA && be_word;
        dp_wr_byte = wr_stb && sel == SEL_DATA && be_byte;
        dp_rd_word = rd_stb && sel == SEL_DATA && be_word;
        dp_rd_byte = rd_stb && sel == SEL_DATA && be_byte;
        ld_rptr    = wr_stb && sel == SEL_RPTR && be_word;
        ld_wptr    = wr_stb && sel == SEL_WPTR && be_word;
    end

    pio_ptr #(.AW(AW)) u_rptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld_rptr),
        .ld_val    (wdata[AW-1:0]),
        .adv       (dp_rd_word | dp_rd_byte),
        .step_word (dp_rd_word),
        .ptr       (rptr)
    );

    pio_ptr #(.AW(AW)) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld_wptr),
        .ld_val    (wdata[AW-1:0]),
        .adv       (dp_wr_word | dp_wr_byte),
        .step_word (dp_wr_word),
        .ptr       (wptr)
    );

    pio_lane_map #(.AW(AW)) u_wmap (
        .ptr       (wptr),
        .even_addr (w_even),
        .odd_addr  (w_odd),
        .low_odd   (w_low_odd)
    );

    pio_lane_map #(.AW(AW)) u_rmap (
        .ptr       (rptr),
        .even_addr (r_even),
        .odd_addr  (r_odd),
        .low_odd   (r_low_odd)
    );

    // Lane write steering: the low byte goes to the lane named by pointer bit 0.
    always_comb begin
        lane_we[0] = dp_wr_word | (dp_wr_byte & ~w_low_odd);
        lane_we[1] = dp_wr_word | (dp_wr_byte &  w_low_odd);
        lane_wa[0] = w_even;
        lane_wa[1] = w_odd;
        lane_wd[0] = w_low_odd ? wdata[15:8] : wdata[7:0];
        lane_wd[1] = w_low_odd ? wdata[7:0]  : wdata[15:8];
        lane_ra[0] = r_even;
        lane_ra[1] = r_odd;
        lane_re    = dp_rd_word | dp_rd_byte;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        pio_lane_ram #(.ENTRIES(LANE_ENTRIES)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lane_we[g]),
            .waddr (lane_wa[g]),
            .wdata (lane_wd[g]),
            .re    (lane_re),
            .raddr (lane_ra[g]),
            .rdata (lane_q[g])
        );
    end

    // Read-side context, captured with the strobe for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_is_data_q <= 1'b0;
            rd_byte_q    <= 1'b0;
            rd_low_odd_q <= 1'b0;
            hold_q       <= '0;
        end else if (rd_stb) begin
            rd_is_data_q <= dp_rd_word | dp_rd_byte;
            rd_byte_q    <= dp_rd_byte;
            rd_low_odd_q <= r_low_odd;
            case (sel)
                SEL_RPTR: hold_q <= 16'(rptr);
                SEL_WPTR: hold_q <= 16'(wptr);
                default:  hold_q <= '0;
            endcase
        end
    end

    // Output byte ordering back to little-endian.
    always_comb begin
        out_lo = rd_low_odd_q ? lane_q[1] : lane_q[0];
        out_hi = rd_low_odd_q ? lane_q[0] : lane_q[1];
        if (!rd_is_data_q)
            rdata = hold_q;
        else if (rd_byte_q)
            rdata = {8'h00, out_lo};
        else
            rdata = {out_hi, out_lo};
    end

    // R1
    reset_ptrs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rptr == '0 && wptr == '0 && rdata == '0));

    // R2
    rload_keeps_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rptr && !dp_wr_word && !dp_wr_byte) |=> $stable(wptr));

    // R3
    word_write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_wr_word |=> wptr == AW'($past(wptr) + AW'(2)));

    // R4
    byte_write_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_wr_byte |-> $countones(lane_we) == 1);

    // R8
    bad_enable_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == SEL_DATA && !be_word && !be_byte) |=> $stable(wptr));

    // R9
    read_keeps_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> $stable(wptr));

    // R9
    write_keeps_rptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel == SEL_DATA && !rd_stb) |=> $stable(rptr));

endmodule

// File: tb/test_pio_window.sv
// Bench for pio_window: directed fills and corner cases, then seeded random
// accesses, all compared against a byte-array model kept by the bench.
module test_pio_window;

    localparam int BANK_BYTES = 64;
    localparam int NUM_BANKS  = 4;
    localparam int SZ         = BANK_BYTES * NUM_BANKS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [1:0]  byte_en = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mdl [SZ];
    int mr = 0;
    int mw = 0;

    always #2.5 clk = ~clk;

    pio_window #(.BANK_BYTES(BANK_BYTES), .NUM_BANKS(NUM_BANKS)) i_pio_window (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .byte_en(byte_en),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; byte_en = be; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, input logic [1:0] be, output logic [15:0] q);
        @(negedge clk);
        reg_sel = s; byte_en = be; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        q = rdata;
    endtask

    // Model of a data-port write.
    task automatic put(input logic [1:0] be, input logic [15:0] d);
        bus_wr(2'd0, be, d);
        if (be == 2'b11) begin
            mdl[mw] = d[7:0];
            mdl[(mw + 1) % SZ] = d[15:8];
            mw = (mw + 2) % SZ;
        end else if (be == 2'b01) begin
            mdl[mw] = d[7:0];
            mw = (mw + 1) % SZ;
        end
    endtask

    // Data-port read checked against the model.
    task automatic get(input logic [1:0] be, input string req);
        logic [15:0] q, e;
        bus_rd(2'd0, be, q);
        if (be == 2'b11) e = {mdl[(mr + 1) % SZ], mdl[mr]};
        else             e = {8'h00, mdl[mr]};
        chk(q === e, req, q, e);
        mr = (mr + ((be == 2'b11) ? 2 : 1)) % SZ;
    endtask

    task automatic load_r(input logic [15:0] v);
        bus_wr(2'd1, 2'b11, v);
        mr = int'(v) % SZ;
    endtask

    task automatic load_w(input logic [15:0] v);
        bus_wr(2'd2, 2'b11, v);
        mw = int'(v) % SZ;
    endtask

    task automatic check_ptrs(input string req);
        logic [15:0] q;
        bus_rd(2'd1, 2'b11, q);
        chk(q === 16'(mr), req, q, 16'(mr));
        bus_rd(2'd2, 2'b11, q);
        chk(q === 16'(mw), req, q, 16'(mw));
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] q;
        logic [15:0] wp;
        logic [7:0]  bp;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata === 16'h0000, "R1 rdata after reset", rdata, 16'h0000);
        check_ptrs("R1 pointers after reset");

        // R2 pointer loads, truncation and independence
        load_w(16'h0005);
        check_ptrs("R2 write pointer load");
        load_r(16'h0010);
        check_ptrs("R2 read pointer load keeps write pointer");
        load_r(16'h1234);
        check_ptrs("R2 load keeps low address bits");

        // R3/R5 word fill with pattern 1 step 3, then verify
        load_w(16'h0000);
        wp = 16'd1;
        for (int i = 0; i < SZ / 2; i++) begin
            put(2'b11, wp);
            wp = wp + 16'd3;
        end
        check_ptrs("R7 write pointer wrapped after full word fill");
        load_r(16'h0000);
        for (int i = 0; i < SZ / 2; i++) get(2'b11, "R3 R5 word pattern readback");
        check_ptrs("R9 reads left write pointer alone");

        // R4/R5 byte fill
        load_w(16'h0000);
        bp = 8'd1;
        for (int i = 0; i < SZ; i++) begin
            put(2'b01, {8'hA5, bp});
            bp = bp + 8'd3;
        end
        load_r(16'h0000);
        for (int i = 0; i < SZ; i++) get(2'b01, "R4 R5 byte pattern readback");

        // R6 odd-offset mixed transfer
        load_w(16'h0007);
        put(2'b01, 16'h0011);
        put(2'b11, 16'h3322);
        put(2'b11, 16'h5544);
        put(2'b01, 16'h0066);
        load_r(16'h0007);
        get(2'b01, "R6 leading byte");
        get(2'b11, "R6 word at even after byte");
        get(2'b11, "R6 second word");
        get(2'b01, "R6 trailing byte");
        load_r(16'h0009);
        get(2'b11, "R6 word read at odd offset");
        check_ptrs("R9 pointers after odd run");

        // R7 word straddling the end of the buffer
        load_w(16'(SZ - 1));
        put(2'b11, 16'hBEEF);
        check_ptrs("R7 write pointer wraps to 1");
        load_r(16'(SZ - 1));
        get(2'b11, "R7 wrapped word");
        load_r(16'h0000);
        get(2'b01, "R7 high byte landed at offset 0");

        // R8 ignored enables
        load_w(16'd20);
        bus_wr(2'd0, 2'b10, 16'hDEAD);
        bus_wr(2'd0, 2'b00, 16'hDEAD);
        check_ptrs("R8 bad enable moved no pointer");
        load_r(16'd20);
        get(2'b11, "R8 bad enable stored nothing");
        bus_wr(2'd1, 2'b01, 16'h0033);
        bus_wr(2'd2, 2'b10, 16'h0044);
        check_ptrs("R8 partial pointer load ignored");
        bus_rd(2'd0, 2'b00, q);
        check_ptrs("R8 bad read enable moved no pointer");

        // Seeded random mix
        for (int n = 0; n < 500; n++) begin
            case ($urandom_range(0, 6))
                0: load_r(16'($urandom));
                1: load_w(16'($urandom));
                2: put(2'b11, 16'($urandom));
                3: put(2'b01, 16'($urandom));
                4: get(2'b11, "R5 R6 random word read");
                5: get(2'b01, "R5 random byte read");
                default: check_ptrs("R9 random pointer readback");
            endcase
        end
        check_ptrs("R9 final pointers");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule